// File: doc/BRIEF.md
# Tear-Free Split-Read Cycle Counter

This block holds a free-running cycle counter that is twice as wide as the read bus. It advances by one on every cycle where the tick enable is high, and it wraps from all-ones to zero. Software reads it as two bus words: the lower half first, then the upper half. When the lower half is read, the block copies the upper half at that same cycle into a holding register. A later upper-half read returns that held copy. This way a carry that lands between the two reads cannot combine a lower half from before the carry with an upper half from after it.

Reads arrive on a request channel with valid/ready handshake and carry a byte offset. Each read gets exactly one registered response on a response channel with valid/ready handshake. A request is accepted only when the response slot is empty or is being drained in the same cycle. While `rsp_ready` is low, a pending response keeps its data unchanged and `req_ready` stays low, so back-pressure reaches the requester. The tick enable is a plain control pin. The counter starts from a reset value given by a parameter.

Top module: `tearfree_counter`

## Requirements
- R1: During and after reset, `rsp_valid` is 0, `req_ready` is 1, the counter holds `INIT_VALUE` and the held upper half is 0.
- R2: The counter increases by exactly one on every clock edge where `tick_en` is 1, and keeps its value on edges where `tick_en` is 0.
- R3: After the all-ones value the counter goes to zero and keeps counting from there.
- R4: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. Its response appears with `rsp_valid` = 1 right after that edge.
- R5: A read at byte offset 0x024 returns the lower 32 counter bits as they stood at the accepting edge, before that edge's increment. At the same edge it loads the upper 32 bits into the held register.
- R6: A read at byte offset 0x028 returns the held register, not the live upper half.
- R7: An upper-half read that has no earlier lower-half read since reset returns 0. Otherwise it returns the value loaded by the most recent lower-half read.
- R8: A read at any other offset returns 0 and leaves the held register unchanged.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and `rsp_data` hold, and `req_ready` is 0.
- R10: A lower-half read followed by an upper-half read gives the full counter value at the lower read's accepting edge, even when the lower half overflows between the two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Advance the counter this cycle |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W (8) | Byte offset of the read |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Requester takes the read data |
| rsp_data | output | DATA_W (32) | Read data |

## Verification
The hard case is a lower-half carry that falls between the two reads of a pair. From reset to zero this takes 2^32 ticks, which a simulation cannot reach. The bench therefore builds the block with `INIT_VALUE` just below the wrap. It then watches its own model of the count and issues the lower-half read exactly two ticks before the overflow. The upper-half read is accepted after the lower bits have wrapped, so it can only pass if the held copy is returned rather than the live value. The same setup also drives the counter through the full all-ones-to-zero wrap.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  localparam logic [7:0] OFS_LOW  = 8'h24;
  localparam logic [7:0] OFS_HIGH = 8'h28;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_LOW  = 2'd1,
    PICK_HIGH = 2'd2
  } pick_e;

  function automatic pick_e decode_ofs(input logic [7:0] ofs);
    if (ofs == OFS_LOW)       return PICK_LOW;
    else if (ofs == OFS_HIGH) return PICK_HIGH;
    else                      return PICK_NONE;
  endfunction
endpackage

// File: rtl/tfc_counter.sv
module tfc_counter #(
  parameter int unsigned       CNT_W      = 64,
  parameter logic [CNT_W-1:0]  INIT_VALUE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= INIT_VALUE;
    else if (tick_en) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/tfc_snapshot.sv
module tfc_snapshot
  import tfc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] live_low,
  input  logic [DATA_W-1:0] live_high,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] held_high
);
  pick_e pick;

  always_comb begin
    pick = decode_ofs(8'(addr));
    unique case (pick)
      PICK_LOW:  rd_word = live_low;
      PICK_HIGH: rd_word = held_high;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        held_high <= '0;
    else if (take && pick == PICK_LOW) held_high <= live_high;
  end
endmodule

// File: rtl/tfc_rsp_stage.sv
module tfc_rsp_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/tearfree_counter.sv
module tearfree_counter #(
  parameter int unsigned          DATA_W     = 32,
  parameter int unsigned          ADDR_W     = 8,
  parameter logic [2*DATA_W-1:0]  INIT_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  count_q;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] rd_word;
  logic              take;

  assign take = req_valid && req_ready;

  tfc_counter #(.CNT_W(CNT_W), .INIT_VALUE(INIT_VALUE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(count_q)
  );

  tfc_snapshot #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .take(take), .addr(req_addr),
    .live_low(count_q[DATA_W-1:0]), .live_high(count_q[CNT_W-1:DATA_W]),
    .rd_word(rd_word), .held_high(shadow_q)
  );

  tfc_rsp_stage #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(rd_word),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(rsp_data)
  );
endmodule

// File: rtl/tearfree_counter_chk.sv
module tearfree_counter_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_en,
  input logic                req_valid,
  input logic                req_ready,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [DATA_W-1:0]   rsp_data,
  input logic [2*DATA_W-1:0] count,
  input logic [DATA_W-1:0]   shadow
);
  logic take_low, take_high;
  assign take_low  = req_valid && req_ready && 8'(req_addr) == 8'h24;
  assign take_high = req_valid && req_ready && 8'(req_addr) == 8'h28;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> count == $past(count) + 1'b1); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count)); // R2
  AST_RSP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R4
  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    take_low |=> shadow == $past(count[2*DATA_W-1:DATA_W])); // R5
  AST_LOW_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    take_low |=> rsp_data == $past(count[DATA_W-1:0])); // R5
  AST_HIGH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    take_high |=> rsp_data == $past(shadow)); // R6
  AST_SHADOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !take_low |=> $stable(shadow)); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data)); // R9
  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R9
endmodule

bind tearfree_counter tearfree_counter_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .count(count_q), .shadow(shadow_q)
);

// File: tb/tearfree_counter_test.sv
module tearfree_counter_test;
  localparam logic [63:0] START = 64'hFFFF_FFFF_FFFF_FF00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_addr = 8'h00;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_data;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tearfree_counter #(.DATA_W(32), .ADDR_W(8), .INIT_VALUE(START)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // behavioural reference model
  logic [63:0] m_cnt;
  logic [31:0] m_shadow;
  logic        m_vld;
  logic [31:0] m_data;
  string       m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = START; m_shadow = 0; m_vld = 0; m_data = 0; m_tag = "R4";
    end else begin
      automatic bit rdy = !m_vld || rsp_ready;
      if (m_vld && rsp_ready) m_vld = 0;
      if (req_valid && rdy) begin
        m_vld = 1;
        if (req_addr == 8'h24) begin
          m_data = m_cnt[31:0]; m_shadow = m_cnt[63:32]; m_tag = "R5";
        end else if (req_addr == 8'h28) begin
          m_data = m_shadow; m_tag = "R6";
        end else begin
          m_data = 0; m_tag = "R8";
        end
      end
      if (tick_en) m_cnt = m_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R9", {63'd0, req_ready}, {63'd0, (!m_vld || rsp_ready)});
      check("R4", {63'd0, rsp_valid}, {63'd0, m_vld});
      if (m_vld) check(m_tag, {32'd0, rsp_data}, {32'd0, m_data});
    end
  end

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data;
    @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d0, d1, lo, hi;
    logic [15:0] lfsr;
    repeat (2) @(negedge clk);
    check("R1", {63'd0, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {62'd0, rsp_valid, req_ready}, 64'd1);

    // R7: upper read before any lower read
    do_read(8'h28, d0);
    check("R7", {32'd0, d0}, 64'd0);

    // R2: counter frozen without tick
    do_read(8'h24, d0);
    do_read(8'h24, d1);
    check("R2", {32'd0, d1}, {32'd0, d0});
    check("R1", {32'd0, d0}, {32'd0, START[31:0]});
    do_read(8'h28, d0);
    check("R7", {32'd0, d0}, {32'd0, START[63:32]});

    // R8: unmapped offsets
    do_read(8'h30, d0);
    check("R8", {32'd0, d0}, 64'd0);
    do_read(8'h2C, d0);
    check("R8", {32'd0, d0}, 64'd0);
    do_read(8'h28, d0);
    check("R8", {32'd0, d0}, {32'd0, START[63:32]});

    // R2: irregular tick pattern with reads in between
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick_en = lfsr[0];
      if (lfsr[3]) do_read(8'h24, d0); else @(negedge clk);
    end
    tick_en = 1'b0;
    do_read(8'h24, d0);
    check("R2", {32'd0, d0}, {32'd0, m_cnt[31:0]});

    // R9: back-pressure
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 8'h24;
    @(negedge clk);
    req_addr = 8'h30;
    d0 = rsp_data;
    repeat (3) @(negedge clk);
    check("R9", {63'd0, req_ready}, 64'd0);
    check("R9", {32'd0, rsp_data}, {32'd0, d0});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);

    // R10: carry between the two reads of a pair
    tick_en = 1'b1;
    while (m_cnt[31:0] != 32'hFFFF_FFFE) @(negedge clk);
    do_read(8'h24, lo);
    do_read(8'h28, hi);
    check("R10", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFFE);
    check("R6", {63'd0, (m_cnt[63:32] != hi)}, 64'd1);

    // R3: full wrap to zero
    do_read(8'h24, lo);
    do_read(8'h28, hi);
    check("R3", {32'd0, hi}, 64'd0);
    check("R3", {63'd0, (lo < 32'd16)}, 64'd1);
    tick_en = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule